// File: doc/BRIEF.md
# History-Indexed Indirect Jump Target Predictor

This block supplies a predicted destination for indirect jumps, whose targets change with the path that led to them. It keeps a two-way set-associative store of resolved targets. The set is picked by folding a global taken/not-taken history register into the word-address bits of the branch address, so one jump site can hold a different target for each recent path. A tag taken from the higher address bits guards each entry against aliasing between sites that map to the same set.

The fetch side presents a lookup with the branch address, a flag that says whether the instruction is an indirect jump, and the target that a branch target buffer has already proposed. Two clocks later the block returns the final target. It takes that target from the store when an indirect jump hits, and passes the buffer's proposal through in every other case. The resolve side sends one update for each resolved branch. Each update shifts that branch's direction into the history. An update for an indirect jump also writes the resolved target into the store, using the history as it stood before the shift.

Top module: `ind_target_cache`

## Requirements
- R1: Synchronous active-high reset clears the prediction outputs to zero, marks every stored entry invalid and sets the history to zero, so the first indirect lookup after reset misses.
- R2: A lookup presented with `lk_valid` high produces `pr_valid` high exactly two rising edges later. `pr_valid` is low in every other cycle.
- R3: A lookup with `lk_is_ind` low returns `pr_tgt` equal to its `lk_btb_tgt` with `pr_hit` low, even when the store holds a matching entry.
- R4: An indirect lookup that matches no valid entry returns its `lk_btb_tgt` with `pr_hit` low.
- R5: An indirect lookup that matches a valid entry returns that entry's stored full target with `pr_hit` high.
- R6: The set index is `pc[IDX_W+1:2]` XOR history, and the tag is `pc[IDX_W+2 +: TAG_W]`. The same address under a different history selects a different set. An address whose index bits differ by exactly the history difference selects the same set.
- R7: Every update with `upd_valid` high shifts `upd_taken` into history bit 0 (1 = taken, 0 = not taken), whether or not it is indirect. An indirect update indexes with the history value from before that shift.
- R8: An indirect update whose tag already sits in the selected set overwrites the target in that same way. A tag is never held in both ways of one set.
- R9: An indirect update that misses writes the way named by the set's LRU bit. Each write, whether a hit or an allocation, points that bit at the other way, so a third tag in a set evicts the least recently written entry. Lookups do not change the LRU bits.
- R10: When a lookup and an update arrive in the same cycle, the lookup sees the store and history as they were before that update.
- R11: With `upd_valid` low, nothing changes. An update with `upd_is_ind` low changes only the history and writes no target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Branch address being predicted |
| lk_is_ind | input | 1 | The lookup is an indirect jump |
| lk_btb_tgt | input | PC_W | Target proposed by the branch target buffer |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_is_ind | input | 1 | The resolved branch is an indirect jump |
| upd_tgt | input | PC_W | Resolved target address |
| pr_valid | output | 1 | Prediction result valid |
| pr_hit | output | 1 | The result came from the target store |
| pr_tgt | output | PC_W | Final predicted target |

## Verification
The bench fills one set with three tags. This catches a replacement policy that evicts the most recent way, or that lets lookups disturb the LRU bit, because either fault makes the wrong tag miss. A same-cycle lookup and update to one address exposes a store that forwards the new target too early. A history change followed by a lookup at an address adjusted by the same XOR catches a hash that ignores the history or misplaces its bits. An indirect update made while history shifts detects a design that indexes with the post-shift value. Non-indirect lookups and updates that hit a filled set show whether the store leaks into non-indirect predictions or is written by non-indirect updates.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int ITC_PC_W  = 32;
  localparam int ITC_IDX_W = 8;
  localparam int ITC_TAG_W = 8;
  localparam int ITC_WAYS  = 2;
endpackage

// File: rtl/itc_hash.sv
module itc_hash #(
  parameter int PC_W  = itc_pkg::ITC_PC_W,
  parameter int IDX_W = itc_pkg::ITC_IDX_W,
  parameter int TAG_W = itc_pkg::ITC_TAG_W
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  localparam int TAG_LSB = IDX_W + 2;

  // word-address bits folded with path history; upper bits form the tag
  assign idx = pc[IDX_W+1:2] ^ hist;
  assign tag = pc[TAG_LSB +: TAG_W];
endmodule

// File: rtl/itc_way.sv
module itc_way #(
  parameter int PC_W  = itc_pkg::ITC_PC_W,
  parameter int IDX_W = itc_pkg::ITC_IDX_W,
  parameter int TAG_W = itc_pkg::ITC_TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_tgt_q,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag,
  output logic             up_hit,
  input  logic             wr_en,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [PC_W-1:0]  tgt_mem [SETS];

  // valid bits live in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[up_idx] <= 1'b1;
  end

  // small tag array read asynchronously for both compare ports
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[up_idx] <= up_tag;
  end

  // target array: single write, registered read (block RAM shape)
  always_ff @(posedge clk) begin
    if (wr_en) tgt_mem[up_idx] <= wr_tgt;
    rd_tgt_q <= tgt_mem[rd_idx];
  end

  assign rd_hit = vld[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign up_hit = vld[up_idx] && (tag_mem[up_idx] == up_tag);

  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(up_idx)]); // R9
endmodule

// File: rtl/itc_lru.sv
module itc_lru #(
  parameter int IDX_W = itc_pkg::ITC_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             victim,
  input  logic             touch_en,
  input  logic             touch_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru;

  always_ff @(posedge clk) begin
    if (rst) lru <= '0;
    else if (touch_en) lru[idx] <= ~touch_way;
  end

  assign victim = lru[idx];

  AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (lru[$past(idx)] != $past(touch_way))); // R9
endmodule

// File: rtl/ind_target_cache.sv
module ind_target_cache #(
  parameter int PC_W  = itc_pkg::ITC_PC_W,
  parameter int IDX_W = itc_pkg::ITC_IDX_W,
  parameter int TAG_W = itc_pkg::ITC_TAG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_is_ind,
  input  logic [PC_W-1:0] lk_btb_tgt,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_is_ind,
  input  logic [PC_W-1:0] upd_tgt,
  output logic            pr_valid,
  output logic            pr_hit,
  output logic [PC_W-1:0] pr_tgt
);
  import itc_pkg::*;
  localparam int NW = ITC_WAYS;

  logic [IDX_W-1:0] ghist;
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [NW-1:0]    lk_hit_w, up_hit_w, wr_w;
  logic [NW-1:0][PC_W-1:0] rd_tgt_w;
  logic             victim, touch_way, upd_write;

  // stage 1 state
  logic             s1_vld, s1_ind;
  logic [NW-1:0]    s1_hit_w;
  logic [PC_W-1:0]  s1_btb;
  logic [PC_W-1:0]  s1_sel;

  itc_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_hash (
    .pc(lk_pc), .hist(ghist), .idx(lk_idx), .tag(lk_tag));

  itc_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_hash (
    .pc(upd_pc), .hist(ghist), .idx(up_idx), .tag(up_tag));

  // global path history
  always_ff @(posedge clk) begin
    if (rst) ghist <= '0;
    else if (upd_valid) ghist <= {ghist[IDX_W-2:0], upd_taken};
  end

  assign upd_write = upd_valid && upd_is_ind;

  always_comb begin
    wr_w = '0;
    if (upd_write) begin
      if (|up_hit_w) wr_w = up_hit_w;
      else           wr_w[victim] = 1'b1;
    end
  end

  assign touch_way = (|up_hit_w) ? up_hit_w[1] : victim;

  generate
    for (genvar w = 0; w < NW; w++) begin : g_way
      itc_way #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(lk_hit_w[w]),
        .rd_tgt_q(rd_tgt_w[w]),
        .up_idx(up_idx), .up_tag(up_tag), .up_hit(up_hit_w[w]),
        .wr_en(wr_w[w]), .wr_tgt(upd_tgt));
    end
  endgenerate

  itc_lru #(.IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .idx(up_idx), .victim(victim),
    .touch_en(upd_write), .touch_way(touch_way));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_ind   <= 1'b0;
      s1_hit_w <= '0;
      s1_btb   <= '0;
    end else begin
      s1_vld   <= lk_valid;
      s1_ind   <= lk_is_ind;
      s1_hit_w <= lk_hit_w;
      s1_btb   <= lk_btb_tgt;
    end
  end

  always_comb begin
    s1_sel = s1_btb;
    for (int w = 0; w < NW; w++)
      if (s1_ind && s1_hit_w[w]) s1_sel = rd_tgt_w[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid <= 1'b0;
      pr_hit   <= 1'b0;
      pr_tgt   <= '0;
    end else begin
      pr_valid <= s1_vld;
      pr_hit   <= s1_vld && s1_ind && (|s1_hit_w);
      pr_tgt   <= s1_sel;
    end
  end

  AST_ONE_WAY_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_w)); // R8
  AST_ONE_WAY_UPDATE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(up_hit_w)); // R8
  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ##1 pr_valid); // R2
  AST_NONIND_PASS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_is_ind) |=> ##1 (!pr_hit && pr_tgt == $past(lk_btb_tgt, 2))); // R3
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (ghist[0] == $past(upd_taken))); // R7
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghist)); // R11
endmodule

// File: tb/test_ind_target_cache.sv
module test_ind_target_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, lk_is_ind = 0, upd_valid = 0, upd_taken = 0, upd_is_ind = 0;
  logic [31:0] lk_pc = 0, lk_btb_tgt = 0, upd_pc = 0, upd_tgt = 0;
  logic pr_valid, pr_hit;
  logic [31:0] pr_tgt;

  int n_chk = 0, n_fail = 0;

  // behavioural model state
  bit          m_vld [256][2];
  bit [7:0]    m_tag [256][2];
  bit [31:0]   m_tgt [256][2];
  bit          m_lru [256];
  bit [7:0]    m_hist;

  // expectations two steps deep
  bit e1_v, e1_h, e2_v, e2_h;
  bit [31:0] e1_t, e2_t;
  string e1_r = "R2", e2_r = "R2";

  always #2.5 clk = ~clk;

  ind_target_cache i_ind_target_cache (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_is_ind(lk_is_ind), .lk_btb_tgt(lk_btb_tgt),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_is_ind(upd_is_ind), .upd_tgt(upd_tgt),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_tgt(pr_tgt));

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] m_idx(bit [31:0] pc);
    return pc[9:2] ^ m_hist;
  endfunction

  task automatic step(bit lv, bit [31:0] lpc, bit lind, bit [31:0] lbtb,
                      bit uv, bit [31:0] upc, bit utk, bit uind, bit [31:0] utgt,
                      string req);
    int hw;
    bit [7:0] i;
    @(negedge clk);
    // compare outputs against the lookup issued two steps ago
    chk(pr_valid == e2_v, e2_r, "pr_valid", 32'(pr_valid), 32'(e2_v));
    if (e2_v) begin
      chk(pr_hit == e2_h, e2_r, "pr_hit", 32'(pr_hit), 32'(e2_h));
      chk(pr_tgt == e2_t, e2_r, "pr_tgt", pr_tgt, e2_t);
    end
    e2_v = e1_v; e2_h = e1_h; e2_t = e1_t; e2_r = e1_r;
    // lookup sees state before this step's update (R10)
    e1_v = lv; e1_h = 0; e1_t = lbtb; e1_r = req;
    if (lv && lind) begin
      i = m_idx(lpc);
      for (int w = 0; w < 2; w++)
        if (m_vld[i][w] && m_tag[i][w] == lpc[17:10]) begin
          e1_h = 1; e1_t = m_tgt[i][w];
        end
    end
    if (uv) begin
      if (uind) begin
        i = m_idx(upc);
        hw = -1;
        for (int w = 0; w < 2; w++)
          if (m_vld[i][w] && m_tag[i][w] == upc[17:10]) hw = w;
        if (hw < 0) hw = int'(m_lru[i]);
        m_vld[i][hw] = 1; m_tag[i][hw] = upc[17:10]; m_tgt[i][hw] = utgt;
        m_lru[i] = (hw == 0);
      end
      m_hist = {m_hist[6:0], utk};
    end
    lk_valid = lv; lk_pc = lpc; lk_is_ind = lind; lk_btb_tgt = lbtb;
    upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_is_ind = uind; upd_tgt = utgt;
  endtask

  task automatic lk(bit [31:0] pc, bit ind, bit [31:0] btb, string req);
    step(1, pc, ind, btb, 0, 0, 0, 0, 0, req);
  endtask

  task automatic up(bit [31:0] pc, bit tk, bit ind, bit [31:0] tgt);
    step(0, 0, 0, 0, 1, pc, tk, ind, tgt, "R2");
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  localparam bit [31:0] PA = 32'h4000_0024;
  localparam bit [31:0] PB = 32'h4000_0424;
  localparam bit [31:0] PC_ = 32'h4000_0824;
  localparam bit [31:0] PD = 32'h4000_0C24;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pr_valid && !pr_hit && pr_tgt == 0, "R1", "reset outputs",
        {pr_tgt[29:0], pr_hit, pr_valid}, 32'h0);
    rst = 0;
    lk(PA, 1, 32'hB000_0001, "R1");        // empty after reset
    lk(PA, 0, 32'hB000_0002, "R3");
    lk(PB, 1, 32'hB000_0003, "R4");
    up(PA, 0, 1, 32'hA000_0010);
    idle(1);
    lk(PA, 1, 32'hB000_0004, "R5");
    lk(PA, 0, 32'hB000_0005, "R3");        // stored entry ignored
    up(PB, 0, 1, 32'hA000_0020);
    lk(PB, 1, 32'hB000_0006, "R5");
    up(PA, 0, 1, 32'hA000_0011);           // hit: overwrite same way
    lk(PA, 1, 32'hB000_0007, "R8");
    lk(PA, 1, 32'hB000_0008, "R9");        // lookup must not refresh LRU
    up(PC_, 0, 1, 32'hA000_0030);          // evicts PB
    lk(PB, 1, 32'hB000_0009, "R9");
    lk(PC_, 1, 32'hB000_000A, "R9");
    lk(PA, 1, 32'hB000_000B, "R9");
    step(0, 0, 0, 0, 0, PA, 1, 1, 32'hDEAD_0000, "R11");
    lk(PA, 1, 32'hB000_000C, "R11");
    up(PA, 0, 0, 32'hDEAD_0001);           // non-indirect: no write
    lk(PA, 1, 32'hB000_000D, "R11");
    step(1, PA, 1, 32'hB000_000E, 1, PA, 0, 1, 32'hA000_0012, "R10");
    lk(PA, 1, 32'hB000_000F, "R10");
    up(32'h4000_5000, 1, 0, 0);            // history -> 1
    lk(PA, 1, 32'hB000_0010, "R6");
    lk(PA ^ 32'h4, 1, 32'hB000_0011, "R6");
    up(PD, 1, 1, 32'hA000_0040);           // indexed with history 1, then -> 3
    lk(32'h4000_0C2C, 1, 32'hB000_0012, "R7");
    lk(PD, 1, 32'hB000_0013, "R7");
    for (int k = 0; k < 400; k++) begin
      bit [31:0] a, b;
      a = PA + (32'($urandom_range(0, 3)) << 10) + (32'($urandom_range(0, 3)) << 2);
      b = PA + (32'($urandom_range(0, 3)) << 10) + (32'($urandom_range(0, 3)) << 2);
      step($urandom_range(0, 1) == 1, a, $urandom_range(0, 3) != 0, $urandom,
           $urandom_range(0, 1) == 1, b, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) != 0, $urandom, "R9");
    end
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule